// File: doc/BRIEF.md
# Core-Style Read/Write-Back Memory Sequencer

This block lets an ordinary static RAM stand in for a destructive-read magnetic core store. Every access a requester launches runs as one fixed-length memory cycle made of two equal halves. In the first half the block reads the addressed RAM word and captures it for the requester. In the second half it writes a word back to the same location. On a load that word is the one just read, so the location is restored. On a store it is the requester's new data. Reads and stores therefore take exactly the same time, and the RAM sees a write in every cycle, the way a core plane would.

A requester raises `start` for one clock while the block is idle, with an address, a store flag and store data. The block takes a copy of these at that edge and works from the copy for the rest of the cycle. Two phase outputs mark the read window and the write window. They never overlap. `done` marks the final clock of the write window. With the defaults, a half lasts three clocks, which matches a 300 ns clock against a 0.9 µs half cycle. The captured read word stays on `rdata` from the end of one read half until the end of the next.

Top module: `core_mem_seq`

## Requirements
- R1: During and after reset the block is idle: `busy`, `phase_rd`, `phase_wr`, `done` and `ram_we` are 0, and `rdata` is 0.
- R2: A `start` seen at a clock edge while idle begins a cycle. For the next HALF_CLKS clocks `phase_rd`=1 and `phase_wr`=0. For the HALF_CLKS clocks after that `phase_wr`=1 and `phase_rd`=0. Then the block is idle again. `busy` is 1 throughout the 2*HALF_CLKS clocks.
- R3: `ram_addr` equals the `addr` sampled with `start` for the whole cycle. Changes on `addr`, `store` or `wdata` after the start edge have no effect on that cycle.
- R4: `rdata` loads the RAM word at the address on the last clock of the read half. It then holds that value until the last read clock of the next cycle, including during that cycle's read half.
- R5: In a load cycle (`store`=0 at start) `ram_we`=1 for every clock of the write half, and `ram_wdata` equals the word read in that cycle, so the location keeps its value.
- R6: In a store cycle (`store`=1 at start) `ram_wdata` during the write half equals the `wdata` sampled at start. `rdata` still returns the location's previous content.
- R7: `done` is 1 for exactly one clock, the last clock of the write half. The block is idle on the following clock.
- R8: `start` while `busy`=1 is ignored. The running cycle keeps its address and length, and no extra cycle follows.
- R9: `ram_we` is never 1 outside the write half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a memory cycle (accepted only when idle) |
| addr | input | ADDR_W | Word address of the request |
| store | input | 1 | 1 = store `wdata`, 0 = load |
| wdata | input | DATA_W | Store data |
| rdata | output | DATA_W | Word read in the latest cycle |
| done | output | 1 | Last clock of the cycle |
| busy | output | 1 | Cycle in progress |
| phase_rd | output | 1 | Read-half window |
| phase_wr | output | 1 | Write-half window |
| ram_addr | output | ADDR_W | RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data (combinational read) |

## Verification
The bench runs loads against a pre-filled RAM at the lowest, highest and middle addresses. This shows that the write-back restores each location unchanged. Stores of all-zeros, all-ones and alternating patterns, each followed by a load of the same word, separate the old value returned in `rdata` from the new value written in the write half. Other cases move the request inputs during a cycle, pulse `start` in the middle of a cycle, and run back-to-back accesses with varied data. These show whether the copy taken at start, the rejection of `start` while busy, and the holding of `rdata` across the next read half behave as required.

// File: rtl/core_mem_seq_pkg.sv
package core_mem_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_READ  = 2'd1,
        SEQ_WRITE = 2'd2
    } seq_state_e;

    // Per-clock control decoded from the sequencer state
    typedef struct packed {
        logic rd_win;   // read half active
        logic wr_win;   // write half active
        logic capture;  // last clock of read half
        logic finish;   // last clock of write half
        logic accept;   // start taken this clock
    } seq_ctl_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/core_mem_seq_timer.sv
module core_mem_seq_timer
    import core_mem_seq_pkg::*;
#(
    parameter int unsigned HALF_CLKS = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output seq_ctl_t ctl
);
    localparam int unsigned CNT_W = cnt_width(HALF_CLKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CLKS - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    assign at_last = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    cnt_q <= '0;
                    if (start) state_q <= SEQ_READ;
                end
                SEQ_READ: begin
                    if (at_last) begin
                        state_q <= SEQ_WRITE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_WRITE: begin
                    if (at_last) begin
                        state_q <= SEQ_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= SEQ_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    always_comb begin
        ctl.rd_win  = (state_q == SEQ_READ);
        ctl.wr_win  = (state_q == SEQ_WRITE);
        ctl.capture = ctl.rd_win && at_last;
        ctl.finish  = ctl.wr_win && at_last;
        ctl.accept  = (state_q == SEQ_IDLE) && start;
    end

    // R2: the write half follows the read half immediately
    assert_read_then_write_R2: assert property (@(posedge clk) disable iff (rst)
        ctl.capture |=> ctl.wr_win);

    // R7: after the final write clock the sequencer is idle
    assert_done_then_idle_R7: assert property (@(posedge clk) disable iff (rst)
        ctl.finish |=> !(ctl.rd_win || ctl.wr_win));

endmodule

// File: rtl/core_mem_seq_latch.sv
module core_mem_seq_latch #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              store_in,
    input  logic [DATA_W-1:0] wdata_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic              store_q,
    output logic [DATA_W-1:0] wdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            store_q <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= addr_in;
            store_q <= store_in;
            wdata_q <= wdata_in;
        end
    end

    // R3: request copy changes only on an accepted start
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !accept |=> ($stable(addr_q) && $stable(store_q) && $stable(wdata_q)));

endmodule

// File: rtl/core_mem_seq_datapath.sv
module core_mem_seq_datapath #(
    parameter int unsigned DATA_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              wr_win,
    input  logic              store_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] rdata_q,
    output logic              ram_we,
    output logic [DATA_W-1:0] ram_wdata
);
    always_ff @(posedge clk) begin
        if (rst)          rdata_q <= '0;
        else if (capture) rdata_q <= ram_rdata;
    end

    assign ram_we    = wr_win;
    assign ram_wdata = store_q ? wdata_q : rdata_q;

endmodule

// File: rtl/core_mem_seq.sv
module core_mem_seq
    import core_mem_seq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned DATA_W    = 20,
    parameter int unsigned HALF_CLKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              store,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic              busy,
    output logic              phase_rd,
    output logic              phase_wr,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata
);
    seq_ctl_t          ctl;
    logic              store_q;
    logic [DATA_W-1:0] wdata_q;

    core_mem_seq_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctl   (ctl)
    );

    core_mem_seq_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .accept   (ctl.accept),
        .addr_in  (addr),
        .store_in (store),
        .wdata_in (wdata),
        .addr_q   (ram_addr),
        .store_q  (store_q),
        .wdata_q  (wdata_q)
    );

    core_mem_seq_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .capture   (ctl.capture),
        .wr_win    (ctl.wr_win),
        .store_q   (store_q),
        .wdata_q   (wdata_q),
        .ram_rdata (ram_rdata),
        .rdata_q   (rdata),
        .ram_we    (ram_we),
        .ram_wdata (ram_wdata)
    );

    assign phase_rd = ctl.rd_win;
    assign phase_wr = ctl.wr_win;
    assign busy     = ctl.rd_win | ctl.wr_win;
    assign done     = ctl.finish;

    // R9: RAM writes only inside the write window
    assert_we_in_write_R9: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (phase_wr && !phase_rd));

    // R4: rdata moves only at the end of a read half
    assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !phase_rd |=> $stable(rdata));

    // R8: a running cycle is not restarted by start
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy && $stable(ram_addr)));

endmodule

// File: tb/core_mem_seq_bench.sv
module core_mem_seq_bench;
    localparam int AW   = 10;
    localparam int DW   = 20;
    localparam int HALF = 3;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          store = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata, ram_wdata, ram_rdata;
    logic [AW-1:0] ram_addr;
    logic          done, busy, phase_rd, phase_wr, ram_we;

    logic [DW-1:0] ram [WORDS];   // RAM model driven by the DUT
    logic [DW-1:0] ref_mem [WORDS]; // bench-side expectation

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] exp_rd;
        logic [DW-1:0] exp_mem;
    } exp_t;
    exp_t sb_q[$];

    int vectors = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [DW-1:0] last_rd = '0;

    always #5 clk = ~clk;

    core_mem_seq u_core_mem_seq (
        .clk(clk), .rst(rst), .start(start), .addr(addr), .store(store),
        .wdata(wdata), .rdata(rdata), .done(done), .busy(busy),
        .phase_rd(phase_rd), .phase_wr(phase_wr), .ram_addr(ram_addr),
        .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    assign ram_rdata = ram[ram_addr];
    always @(posedge clk) if (ram_we) ram[ram_addr] <= ram_wdata;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: pop the expected item at the done clock and compare
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R7 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(rdata == e.exp_rd, "R4 rdata", rdata, e.exp_rd);
                chk(ram[e.a] == e.exp_mem, "R5/R6 memory after write-back",
                    ram[e.a], e.exp_mem);
            end
        end
    end

    // Driver: one access, checking phases at each clock of the cycle
    task automatic access(input logic [AW-1:0] a, input bit st,
                          input logic [DW-1:0] d, input bit poke_mid);
        exp_t e;
        logic [DW-1:0] wb;
        e.a = a;
        e.exp_rd = ref_mem[a];
        wb = st ? d : ref_mem[a];
        e.exp_mem = wb;
        ref_mem[a] = wb;
        sb_q.push_back(e);
        @(negedge clk);
        start = 1'b1; addr = a; store = st; wdata = d;
        @(negedge clk);
        start = 1'b0;
        addr = ~a; store = ~st; wdata = ~d; // R3: late changes must not matter
        for (int i = 0; i < 2*HALF; i++) begin
            bit in_rd;
            in_rd = (i < HALF);
            chk(phase_rd == in_rd && phase_wr == !in_rd, "R2 phase windows",
                {phase_rd, phase_wr}, {in_rd, !in_rd});
            chk(busy == 1'b1, "R2 busy", busy, 1);
            chk(ram_addr == a, "R3 address held", ram_addr, a);
            chk(done == (i == 2*HALF-1), "R7 done pulse", done, (i == 2*HALF-1));
            if (in_rd) begin
                chk(ram_we == 1'b0, "R9 no write in read half", ram_we, 0);
                chk(rdata == last_rd, "R4 rdata held in read half", rdata, last_rd);
            end else begin
                chk(ram_we == 1'b1, "R5 write enable in write half", ram_we, 1);
                chk(ram_wdata == wb, st ? "R6 store data" : "R5 write-back data",
                    ram_wdata, wb);
                chk(rdata == e.exp_rd, "R6 rdata is old content", rdata, e.exp_rd);
            end
            if (poke_mid && i == 1) begin
                start = 1'b1; addr = a ^ 10'h155; // R8: mid-cycle start
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(busy == 1'b0 && done == 1'b0, poke_mid ? "R8 no extra cycle" : "R7 idle after done",
            {busy, done}, 0);
        chk(ram_we == 1'b0, "R9 no write while idle", ram_we, 0);
        chk(rdata == e.exp_rd, "R4 rdata held after cycle", rdata, e.exp_rd);
        last_rd = e.exp_rd;
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            ram[i] = DW'((i * 37) ^ 20'h5A5A5);
            ref_mem[i] = DW'((i * 37) ^ 20'h5A5A5);
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({busy, phase_rd, phase_wr, done, ram_we} == 5'b0, "R1 idle in reset",
            {busy, phase_rd, phase_wr, done, ram_we}, 0);
        chk(rdata == '0, "R1 rdata in reset", rdata, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && ram_we == 1'b0, "R1 idle after reset", {busy, ram_we}, 0);

        // Loads at edge and middle addresses (R5 restores content)
        access(10'h000, 1'b0, '0, 1'b0);
        access(10'h3FF, 1'b0, '0, 1'b0);
        access(10'h200, 1'b0, '0, 1'b0);
        // Stores then read-back (R6)
        access(10'h010, 1'b1, 20'h00000, 1'b0);
        access(10'h010, 1'b0, '0, 1'b0);
        access(10'h011, 1'b1, 20'hFFFFF, 1'b0);
        access(10'h011, 1'b0, '0, 1'b0);
        access(10'h3FF, 1'b1, 20'hAAAAA, 1'b0);
        access(10'h3FF, 1'b1, 20'h55555, 1'b0);
        access(10'h3FF, 1'b0, '0, 1'b0);
        // Start while busy (R8)
        access(10'h0AA, 1'b0, '0, 1'b1);
        access(10'h0AA, 1'b1, 20'h12345, 1'b1);
        access(10'h0AA ^ 10'h155, 1'b0, '0, 1'b0);
        access(10'h0AA, 1'b0, '0, 1'b0);
        // Mixed sequence
        for (int k = 0; k < 24; k++) begin
            access(AW'(k * 91 + 7), k[0], DW'(k * 24593 + 11), 1'b0);
        end
        repeat (2) @(negedge clk);
        chk(sb_q.size() == 0, "R7 every cycle signalled done", sb_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule